// File: doc/BRIEF.md
# Standby Mode Controller

This block decides when a small processor core may enter a low-power standby state, and when it leaves it again. Software asks for standby by writing a sleep-request bit, a stop-request bit or both. The controller compares that write with the interrupt request lines. Each request line carries its own 2-bit priority. The controller either enters the requested mode or drops the write without effect. A drop happens when any request of useful priority is pending. It does not matter whether the core would actually take that interrupt.

In sleep the core clock is gated and the oscillator keeps running. In stop the oscillator is also switched off. Any request of useful priority ends standby. After a stop exit the core clock stays gated for two further periods: an oscillator settling time, chosen from four taps of a free-running time-base counter, and then a fixed regulator recovery count. On the cycle the core clock returns, a one-cycle wake pulse is raised. A companion flag on that pulse tells the core what to do next. It either branches to the interrupt handler or carries on with the instruction that follows the standby write. The flag is set only when the waking request outranks the core's current interrupt level and interrupts are globally enabled.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the power state is run (state code 0). The core clock enable and the oscillator enable are 1. Both standby readback bits and the wake outputs are 0.
- R2: A write made in run with only the sleep bit set, and with no qualifying request, moves the state to sleep (code 1) on the next clock edge. In sleep the core clock enable is 0, the oscillator enable stays 1 and the sleep readback bit is 1. Writes made while in any standby state have no effect.
- R3: A write made in run with the stop bit set, with or without the sleep bit, and with no qualifying request, moves the state to stop (code 2) on the next edge. In stop both the core clock enable and the oscillator enable are 0, and the stop readback bit is 1.
- R4: A request qualifies when its line is high and its priority field (bits [2i+1:2i] of the priority bus for line i) is not 2'b11. A standby write made while any request qualifies leaves the state in run. Requests at priority 2'b11 neither block entry nor wake the block.
- R5: A refused standby write is not stored. Once the blocking request is gone, the state stays in run until software writes again.
- R6: In sleep, a qualifying request returns the state to run on the next edge. wake_o is high for exactly that one cycle, and the sleep readback bit returns to 0.
- R7: wake_branch_o is 1 alongside wake_o only if interrupts are enabled and the numerically smallest qualifying priority is strictly smaller than the core level (00 is highest). This is sampled on the release edge; otherwise it is 0.
- R8: In stop, a qualifying request moves the state to settling (code 3) on the next edge, with the oscillator enabled and the core clock still gated. Settling lasts exactly 2^(10+2*sel)+256 cycles, where sel is the delay select latched on the stop-entry write. The state then returns to run with a wake_o pulse, and the stop readback bit returns to 0.

Top module ports below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Standby control write strobe |
| wr_stop_i | input | 1 | Stop-request bit of the write |
| wr_sleep_i | input | 1 | Sleep-request bit of the write |
| dly_sel_i | input | 2 | Settling delay select, latched on stop entry |
| irq_req_i | input | 4 | Interrupt request lines |
| irq_prio_i | input | 8 | 2-bit priority per request line |
| cpu_lvl_i | input | 2 | Current interrupt level of the core |
| cpu_ie_i | input | 1 | Global interrupt enable of the core |
| state_o | output | 2 | Power state: 0 run, 1 sleep, 2 stop, 3 settling |
| stop_bit_o | output | 1 | Stop readback bit |
| sleep_bit_o | output | 1 | Sleep readback bit |
| cpu_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| wake_o | output | 1 | One-cycle pulse when the core clock resumes |
| wake_branch_o | output | 1 | Branch to the handler (1) or resume in line (0) |

## Verification
The bench targets the priority boundary at 2'b11. A design that treats the lowest level as qualifying would refuse valid writes and wake on requests that should be ignored. It writes both request bits at once, which exposes a design that enters sleep instead of stop. It repeats a write after a refusal, which catches a controller that stores the refused request and enters standby later. It tests the branch flag at a priority equal to the core level and with interrupts disabled; either case would cause a wrong branch. It measures the gated-clock window after a stop exit for every select value. That catches an off-by-one in the limit, a wrong tap, or a missing regulator count.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_STOP   = 2'd2,
    PS_SETTLE = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/stby_irq_qual.sv
module stby_irq_qual #(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 2
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    any_o,
  output logic [PRIO_W-1:0]       best_o
);
  localparam logic [PRIO_W-1:0] LOWEST = '1;

  logic [N_SRC-1:0] qual;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_qual
      assign qual[g] = req_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != LOWEST);
    end
  endgenerate

  always_comb begin
    best_o = LOWEST;
    for (int i = 0; i < N_SRC; i++) begin
      if (qual[i] && (prio_i[i*PRIO_W +: PRIO_W] < best_o))
        best_o = prio_i[i*PRIO_W +: PRIO_W];
    end
  end

  assign any_o = |qual;

  always_comb begin
    if (any_o) AST_BEST_QUALIFIES: assert (best_o != LOWEST); // R4
  end
endmodule

// File: rtl/stby_timebase.sv
module stby_timebase #(
  parameter int TB_W = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [TB_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end

  AST_TB_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R8
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int PRIO_W   = 2,
  parameter int SEL_W    = 2,
  parameter int TB_W     = 17,
  parameter int TAP_BASE = 10,
  parameter int TAP_STEP = 2,
  parameter int REGU_CNT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_stop_i,
  input  logic              wr_sleep_i,
  input  logic [SEL_W-1:0]  dly_sel_i,
  input  logic              any_i,
  input  logic [PRIO_W-1:0] best_i,
  input  logic [PRIO_W-1:0] cpu_lvl_i,
  input  logic              cpu_ie_i,
  input  logic [TB_W-1:0]   tb_cnt_i,
  output logic              tb_clr_o,
  output pwr_state_e        state_o,
  output logic              wake_o,
  output logic              wake_branch_o
);
  pwr_state_e       state_q;
  logic [SEL_W-1:0] sel_q;
  logic [TB_W-1:0]  lim;
  logic             branch_now;
  logic             entry_req;

  assign entry_req  = wr_en_i && (wr_stop_i || wr_sleep_i) && !any_i;
  assign branch_now = cpu_ie_i && (best_i < cpu_lvl_i);
  assign lim = (TB_W'(1) << (TAP_BASE + TAP_STEP * int'(sel_q))) + TB_W'(REGU_CNT - 1);
  assign tb_clr_o = (state_q == PS_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= PS_RUN;
      sel_q         <= '0;
      wake_o        <= 1'b0;
      wake_branch_o <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      unique case (state_q)
        PS_RUN: begin
          if (entry_req) begin
            if (wr_stop_i) begin
              state_q <= PS_STOP;
              sel_q   <= dly_sel_i;
            end else begin
              state_q <= PS_SLEEP;
            end
          end
        end
        PS_SLEEP: begin
          if (any_i) begin
            state_q       <= PS_RUN;
            wake_o        <= 1'b1;
            wake_branch_o <= branch_now;
          end
        end
        PS_STOP: begin
          if (any_i) begin
            state_q       <= PS_SETTLE;
            wake_branch_o <= branch_now;
          end
        end
        PS_SETTLE: begin
          if (tb_cnt_i == lim) begin
            state_q <= PS_RUN;
            wake_o  <= 1'b1;
          end
        end
        default: state_q <= PS_RUN;
      endcase
    end
  end

  assign state_o = state_q;

  AST_ENTRY_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RUN && any_i) |=> (state_q == PS_RUN)); // R4
  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RUN && wr_en_i && wr_stop_i && !any_i) |=> (state_q == PS_STOP)); // R3
  AST_SLEEP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SLEEP && any_i) |=> (state_q == PS_RUN && wake_o)); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_STOP && any_i) |=> (state_q == PS_SETTLE)); // R8
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R6
  AST_WAKE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (state_q == PS_RUN)); // R8
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int N_SRC    = 4,
  parameter int PRIO_W   = 2,
  parameter int SEL_W    = 2,
  parameter int TAP_BASE = 10,
  parameter int TAP_STEP = 2,
  parameter int REGU_CNT = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_stop_i,
  input  logic                    wr_sleep_i,
  input  logic [SEL_W-1:0]        dly_sel_i,
  input  logic [N_SRC-1:0]        irq_req_i,
  input  logic [N_SRC*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]       cpu_lvl_i,
  input  logic                    cpu_ie_i,
  output logic [1:0]              state_o,
  output logic                    stop_bit_o,
  output logic                    sleep_bit_o,
  output logic                    cpu_clk_en_o,
  output logic                    osc_en_o,
  output logic                    wake_o,
  output logic                    wake_branch_o
);
  localparam int N_SEL   = 1 << SEL_W;
  localparam int TAP_MAX = TAP_BASE + TAP_STEP * (N_SEL - 1);
  localparam int TB_W    = $clog2((1 << TAP_MAX) + REGU_CNT);

  logic              any_q;
  logic [PRIO_W-1:0] best;
  logic [TB_W-1:0]   tb_cnt;
  logic              tb_clr;
  pwr_state_e        st;

  stby_irq_qual #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_qual (
    .req_i (irq_req_i),
    .prio_i(irq_prio_i),
    .any_o (any_q),
    .best_o(best)
  );

  stby_timebase #(.TB_W(TB_W)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tb_clr),
    .cnt_o (tb_cnt)
  );

  stby_fsm #(
    .PRIO_W(PRIO_W), .SEL_W(SEL_W), .TB_W(TB_W),
    .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP), .REGU_CNT(REGU_CNT)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_stop_i    (wr_stop_i),
    .wr_sleep_i   (wr_sleep_i),
    .dly_sel_i    (dly_sel_i),
    .any_i        (any_q),
    .best_i       (best),
    .cpu_lvl_i    (cpu_lvl_i),
    .cpu_ie_i     (cpu_ie_i),
    .tb_cnt_i     (tb_cnt),
    .tb_clr_o     (tb_clr),
    .state_o      (st),
    .wake_o       (wake_o),
    .wake_branch_o(wake_branch_o)
  );

  assign state_o      = st;
  assign stop_bit_o   = (st == PS_STOP) || (st == PS_SETTLE);
  assign sleep_bit_o  = (st == PS_SLEEP);
  assign cpu_clk_en_o = (st == PS_RUN);
  assign osc_en_o     = (st != PS_STOP);

  AST_STOP_OSC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == PS_STOP && !any_q) |=> !osc_en_o); // R3
  AST_SETTLE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == PS_STOP && any_q) |=> (osc_en_o && !cpu_clk_en_o)); // R8
endmodule

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_stop = 1'b0, wr_sleep = 1'b0;
  logic [1:0] dly_sel = 2'd0;
  logic [3:0] req = 4'h0;
  logic [7:0] prio = 8'hFF;
  logic [1:0] lvl = 2'b11;
  logic       ie = 1'b0;
  logic [1:0] state;
  logic       stop_bit, sleep_bit, clk_en, osc_en, wake, wake_br;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stby_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_stop_i(wr_stop),
    .wr_sleep_i(wr_sleep), .dly_sel_i(dly_sel), .irq_req_i(req),
    .irq_prio_i(prio), .cpu_lvl_i(lvl), .cpu_ie_i(ie), .state_o(state),
    .stop_bit_o(stop_bit), .sleep_bit_o(sleep_bit), .cpu_clk_en_o(clk_en),
    .osc_en_o(osc_en), .wake_o(wake), .wake_branch_o(wake_br)
  );

  // {stop, sleep, req[3:0], prio[7:0], expected state}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 1'b1, 4'b0000, 8'hFF, 2'd1},
    {1'b1, 1'b0, 4'b0000, 8'hFF, 2'd2},
    {1'b1, 1'b1, 4'b0000, 8'hFF, 2'd2},
    {1'b0, 1'b1, 4'b0001, 8'hFD, 2'd0},
    {1'b1, 1'b0, 4'b0100, 8'hFF, 2'd2},
    {1'b0, 1'b1, 4'b1010, 8'hF3, 2'd0},
    {1'b0, 1'b1, 4'b1001, 8'hBF, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input logic s, input logic l);
    wr_en = 1'b1; wr_stop = s; wr_sleep = l;
    tick();
    wr_en = 1'b0; wr_stop = 1'b0; wr_sleep = 1'b0;
  endtask

  // raise a top-priority request until back in run
  task automatic go_run();
    int n;
    n = 0;
    req = 4'b0001; prio = 8'hFC;
    while (state != 2'd0 && n < 70000) begin
      tick();
      n++;
      if (state != 2'd0) begin req = 4'h0; prio = 8'hFF; end
    end
    req = 4'h0; prio = 8'hFF;
    tick();
  endtask

  initial begin
    #(10 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #22 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 state", state, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 bits", {stop_bit, sleep_bit, wake, wake_br}, 0);

    // table: entry decisions
    for (int i = 0; i < 7; i++) begin
      req = VEC[i][13:10]; prio = VEC[i][9:2];
      do_write(VEC[i][15], VEC[i][14]);
      req = 4'h0; prio = 8'hFF;
      chk((VEC[i][1:0] == 2'd0) ? "R4 refused" :
          (VEC[i][15] ? "R3 stop entry" : "R2 sleep entry"), state, VEC[i][1:0]);
      if (VEC[i][1:0] == 2'd1) chk("R2 sleep gating", {clk_en, osc_en, sleep_bit}, 3'b011);
      if (VEC[i][1:0] == 2'd2) chk("R3 stop gating", {clk_en, osc_en, stop_bit}, 3'b001);
      if (state != 2'd0) go_run();
    end

    // R5 refused write not remembered
    req = 4'b0010; prio = 8'hF7;
    do_write(1'b0, 1'b1);
    req = 4'h0; prio = 8'hFF;
    for (int k = 0; k < 5; k++) tick();
    chk("R5 not remembered", state, 0);

    // R2 writes ignored in sleep; R4 low priority does not wake
    do_write(1'b0, 1'b1);
    do_write(1'b1, 1'b0);
    chk("R2 write in sleep ignored", state, 1);
    req = 4'b1111; prio = 8'hFF;
    tick(); tick();
    chk("R4 prio 11 no wake", state, 1);

    // R6 / R7 sleep release with branch
    lvl = 2'b01; ie = 1'b1;
    req = 4'b0100; prio = 8'hCF;
    tick();
    req = 4'h0; prio = 8'hFF;
    chk("R6 sleep release", {state, wake, sleep_bit}, {2'd0, 1'b1, 1'b0});
    chk("R7 branch taken", wake_br, 1);
    tick();
    chk("R6 wake one cycle", wake, 0);

    // R7 equal priority -> resume
    do_write(1'b0, 1'b1);
    req = 4'b0001; prio = 8'hFD;
    tick();
    req = 4'h0; prio = 8'hFF;
    chk("R7 equal level resume", {wake, wake_br}, 2'b10);

    // R7 interrupts disabled -> resume
    ie = 1'b0;
    do_write(1'b0, 1'b1);
    req = 4'b0001; prio = 8'hFC;
    tick();
    req = 4'h0; prio = 8'hFF;
    chk("R7 disabled resume", {wake, wake_br}, 2'b10);
    ie = 1'b1; lvl = 2'b11;

    // R8 settle length for each select
    for (int s = 0; s < 4; s++) begin
      int cnt;
      int exp_len;
      exp_len = (1 << (10 + 2 * s)) + 256;
      dly_sel = 2'(s);
      do_write(1'b1, 1'b0);
      dly_sel = 2'(3 - s);
      tick();
      chk("R3 stop held", {state, osc_en}, {2'd2, 1'b0});
      req = 4'b1000; prio = 8'h3F;
      tick();
      req = 4'h0; prio = 8'hFF;
      chk("R8 settle entry", {state, osc_en, clk_en}, {2'd3, 1'b1, 1'b0});
      cnt = 0;
      while (state == 2'd3 && cnt < 70000) begin
        if (clk_en !== 1'b0) cnt = 99999;
        cnt++;
        tick();
      end
      chk("R8 settle cycles", cnt, exp_len);
      chk("R8 exit wake", {state, wake, wake_br, stop_bit}, {2'd0, 1'b1, 1'b1, 1'b0});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule